// File: doc/BRIEF.md
# LVDS Transmitter Power Sequencer

This block takes an LVDS transmitter from fully off to driving its output, and back to off, by issuing an ordered series of control-word writes. A single-cycle enable or disable request starts a sequence. The configuration inputs are sampled in the cycle the request is accepted. They select the variant: older or newer generation, simple or extended PLL, whether a normal-mode bit exists, whether a separate PHY enable is needed, whether striping hardware exists, whether a companion transmitter is present, and which dual-link pixel order is used. The requested pixel frequency is sampled at the same time. It is clamped to the range the PLL supports and turned into a PLL band code.

Each write leaves on a valid/ready stream. A beat carries the target unit (0 = primary, 1 = companion), a 3-bit register selector and a 16-bit data word. The stream follows the usual back-pressure rules. A beat transfers on a clock edge where both valid and ready are high. While valid is high and ready is low, the beat stays presented and unchanged. `busy` is high from the cycle after a request is accepted until the last beat has transferred. For the simple PLL, the sequencer pauses before the final output-release write. The pause is counted in clock cycles, as microseconds times cycles-per-microsecond.

Top module: `lvds_pwrseq`

## Requirements
- R1: On an accepted enable, `freq_eff_khz` becomes the requested frequency clamped to [5000, 148500] kHz when `ext_pll` is 1, and to [31000, 148500] kHz otherwise. It is visible in the cycle after acceptance.
- R2: Older generation (`gen_new`=0): the PLL word (register 3) has the band code in bits 1:0. The code is 0 below 39000 kHz, 1 below 61000 kHz, 2 below 121000 kHz and 3 otherwise. Bits 4 and 5 are set for codes 0 to 2 and clear for code 3.
- R3: Newer generation: the band code switches at 42000, 85000 and 128000 kHz, and bits 4 and 5 stay clear. With `ext_pll`=1, bit 8 of the PLL word is also set.
- R4: Per unit, the enable order is as follows. Register 0 is written with 0x0039 (routing) and register 1 with 0x00E4 (lane map). Register 2 (stripe) is written only when `dual_cap`=1. Register 3 (PLL) is written unless the PLL is skipped. Register 4 (main) is then written with `mode_code` in bits 2:0 and `src_sel` in bit 3, and register 5 (channel) with 0x001F.
- R5: Each following main write adds to the previous main value. An older generation adds bias (bit 4) and PHY (bit 5) together. A simple PLL adds PLL-on (bit 6). When `has_pwd`=1, normal mode (bit 7) is added. When `sep_phy`=1 and `has_pwd`=0, PHY (bit 5) is added in its own write.
- R6: The last write of each unit's enable is the main word with output release (bit 8). When `sep_phy`=1, this word also carries bit 5, so with `has_pwd`=1 the PHY enable is committed only here.
- R7: With a simple PLL, the release write transfers START_US*CLK_PER_US+1 cycles after the previous transfer when ready stays high. With the extended PLL it transfers in the next cycle.
- R8: Dual link means `dual_cap`=1 and `link_mode`≠0 (1 = even pixels first, 2 = odd pixels first). If `comp_present`=1, the whole companion sequence (unit 1) runs first. The stripe word has bit 0 set in dual link. Bit 1 (swap) is set only on the primary unit, with a companion present and `link_mode`=2. The PLL write is skipped on unit 1, and also on unit 0 when dual link has no companion.
- R9: A disable writes 0 to registers 4, 5 and 3 of unit 0, in that order. It then does the same on unit 1 when dual link has a companion.
- R10: Requests are accepted only while idle. A request that arrives while `busy` is high has no effect on the writes or on `freq_eff_khz`. When enable and disable arrive together, enable wins.
- R11: While `wr_valid`=1 and `wr_ready`=0, the beat is held stable until it transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the delay time base |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| freq_khz | input | FREQ_W | Requested pixel frequency in kHz |
| gen_new | input | 1 | 1 = newer generation |
| ext_pll | input | 1 | 1 = extended PLL present |
| has_pwd | input | 1 | 1 = normal-mode bit exists |
| sep_phy | input | 1 | 1 = separate PHY enable required |
| dual_cap | input | 1 | 1 = stripe hardware present |
| comp_present | input | 1 | 1 = companion transmitter attached |
| link_mode | input | 2 | 0 single, 1 even-first, 2 odd-first |
| mode_code | input | 3 | Data mapping mode for the main word |
| src_sel | input | 1 | Input source select for the main word |
| busy | output | 1 | Sequence in progress |
| freq_eff_khz | output | FREQ_W | Clamped frequency |
| wr_valid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat accepted |
| wr_unit | output | 1 | 0 primary, 1 companion |
| wr_reg | output | 3 | Register selector |
| wr_data | output | 16 | Register data word |

## Verification
The first write beat is presented in the cycle after a request is accepted, and `freq_eff_khz` and `busy` change in that same cycle. With ready held high, each following beat transfers one cycle after the one before it. The exception is the simple-PLL release, which comes START_US*CLK_PER_US+1 cycles after its predecessor. A monitor samples the stream on the falling edge, stamps each transfer with the next rising edge, and checks the gap between transfers against the value queued with the expected beat. While back-pressure is applied, gap checks are switched off and only order and content are compared. Ignored requests are detected as unexpected beats, or as a changed `freq_eff_khz`, before the bench waits for the sequence to finish.

// File: rtl/lvds_pwrseq_pkg.sv
package lvds_pwrseq_pkg;
  localparam int WORD_W = 16;
  localparam int REG_W  = 3;

  localparam logic [REG_W-1:0] RG_ROUTE  = 3'd0;
  localparam logic [REG_W-1:0] RG_LANE   = 3'd1;
  localparam logic [REG_W-1:0] RG_STRIPE = 3'd2;
  localparam logic [REG_W-1:0] RG_PLL    = 3'd3;
  localparam logic [REG_W-1:0] RG_MAIN   = 3'd4;
  localparam logic [REG_W-1:0] RG_CHAN   = 3'd5;

  localparam logic [WORD_W-1:0] ROUTE_WORD = 16'h0039;
  localparam logic [WORD_W-1:0] LANE_WORD  = 16'h00E4;
  localparam logic [WORD_W-1:0] CHAN_WORD  = 16'h001F;

  // main word bit positions
  localparam int MB_SRC   = 3;
  localparam int MB_BIAS  = 4;
  localparam int MB_PHY   = 5;
  localparam int MB_PLLON = 6;
  localparam int MB_NORM  = 7;
  localparam int MB_REL   = 8;

  // PLL word bit positions
  localparam int PB_CE  = 4;
  localparam int PB_CO  = 5;
  localparam int PB_EXT = 8;

  // frequency limits in kHz
  localparam int F_MIN_EXT = 5000;
  localparam int F_MIN_STD = 31000;
  localparam int F_MAX     = 148500;
  localparam int OLD_T1 = 39000;
  localparam int OLD_T2 = 61000;
  localparam int OLD_T3 = 121000;
  localparam int NEW_T1 = 42000;
  localparam int NEW_T2 = 85000;
  localparam int NEW_T3 = 128000;

  typedef struct packed {
    logic       gen_new;
    logic       ext_pll;
    logic       has_pwd;
    logic       sep_phy;
    logic       dual_cap;
    logic       comp_present;
    logic [1:0] link_mode;
    logic [2:0] mode_code;
    logic       src_sel;
  } seq_cfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ROUTE, S_LANE, S_STRIPE, S_PLL, S_MODE, S_CHAN, S_BIAS,
    S_PLLON, S_NORM, S_PHY, S_WAIT, S_REL, S_OFF_MAIN, S_OFF_CHAN, S_OFF_PLL
  } step_e;
endpackage

// File: rtl/lvds_freq_band.sv
module lvds_freq_band
  import lvds_pwrseq_pkg::*;
#(
  parameter int FREQ_W = 18
) (
  input  logic [FREQ_W-1:0] freq_in,
  input  logic              gen_new,
  input  logic              ext_pll,
  output logic [FREQ_W-1:0] freq_eff,
  output logic [WORD_W-1:0] pll_word
);
  localparam logic [FREQ_W-1:0] LO_EXT = FREQ_W'(F_MIN_EXT);
  localparam logic [FREQ_W-1:0] LO_STD = FREQ_W'(F_MIN_STD);
  localparam logic [FREQ_W-1:0] HI     = FREQ_W'(F_MAX);

  logic [FREQ_W-1:0] lo;
  logic [1:0]        band;

  always_comb begin
    lo = ext_pll ? LO_EXT : LO_STD;
    if (freq_in < lo)      freq_eff = lo;
    else if (freq_in > HI) freq_eff = HI;
    else                   freq_eff = freq_in;
  end

  always_comb begin
    if (gen_new) begin
      if      (freq_eff < FREQ_W'(NEW_T1)) band = 2'd0;
      else if (freq_eff < FREQ_W'(NEW_T2)) band = 2'd1;
      else if (freq_eff < FREQ_W'(NEW_T3)) band = 2'd2;
      else                                 band = 2'd3;
    end else begin
      if      (freq_eff < FREQ_W'(OLD_T1)) band = 2'd0;
      else if (freq_eff < FREQ_W'(OLD_T2)) band = 2'd1;
      else if (freq_eff < FREQ_W'(OLD_T3)) band = 2'd2;
      else                                 band = 2'd3;
    end
    pll_word         = '0;
    pll_word[1:0]    = band;
    pll_word[PB_CE]  = !gen_new && (band != 2'd3);
    pll_word[PB_CO]  = !gen_new && (band != 2'd3);
    pll_word[PB_EXT] = ext_pll;
  end
endmodule

// File: rtl/lvds_start_timer.sv
module lvds_start_timer #(
  parameter int CLK_PER_US = 8,
  parameter int START_US   = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int LIMIT = CLK_PER_US * START_US;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (run) cnt <= cnt + 1'b1;
    else          cnt <= '0;
  end

  assign done = run && (cnt == CW'(LIMIT - 1));

  // the count restarts whenever the wait is left
  assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/lvds_seq_fsm.sv
module lvds_seq_fsm
  import lvds_pwrseq_pkg::*;
#(
  parameter int FREQ_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              dis_req,
  input  seq_cfg_t          cfg_in,
  input  logic [FREQ_W-1:0] freq_in,
  input  logic [WORD_W-1:0] pll_word,
  input  logic              tmr_done,
  output seq_cfg_t          cfg_q,
  output logic [FREQ_W-1:0] freq_q,
  output logic              busy,
  output logic              tmr_run,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_unit,
  output logic [REG_W-1:0]  wr_reg,
  output logic [WORD_W-1:0] wr_data
);
  step_e             step_q, nxt;
  logic              unit_q, unit_nxt;
  logic [WORD_W-1:0] main_q, base;
  logic              dual, skip_pll, swap, dual_in, accept, xfer;
  step_e             a_lane, a_stripe, a_chan, a_bias, a_pllon, a_norm, a_phy;

  assign dual     = cfg_q.dual_cap && (cfg_q.link_mode != 2'd0);
  assign dual_in  = cfg_in.dual_cap && (cfg_in.link_mode != 2'd0);
  assign skip_pll = unit_q || (dual && !cfg_q.comp_present);
  assign swap     = !unit_q && dual && cfg_q.comp_present && (cfg_q.link_mode == 2'd2);
  assign accept   = (step_q == S_IDLE) && (en_req || dis_req);
  assign busy     = (step_q != S_IDLE);
  assign tmr_run  = (step_q == S_WAIT);
  assign wr_valid = (step_q != S_IDLE) && (step_q != S_WAIT);
  assign wr_unit  = unit_q;
  assign xfer     = wr_valid && wr_ready;

  always_comb begin
    base = '0;
    base[2:0]    = cfg_q.mode_code;
    base[MB_SRC] = cfg_q.src_sel;
  end

  // variant-dependent skip chain
  always_comb begin
    a_phy    = cfg_q.ext_pll ? S_REL : S_WAIT;
    a_norm   = (cfg_q.sep_phy && !cfg_q.has_pwd) ? S_PHY : a_phy;
    a_pllon  = cfg_q.has_pwd ? S_NORM : a_norm;
    a_bias   = cfg_q.ext_pll ? a_pllon : S_PLLON;
    a_chan   = cfg_q.gen_new ? a_bias : S_BIAS;
    a_stripe = skip_pll ? S_MODE : S_PLL;
    a_lane   = cfg_q.dual_cap ? S_STRIPE : a_stripe;
  end

  always_comb begin
    nxt      = S_IDLE;
    unit_nxt = unit_q;
    case (step_q)
      S_ROUTE:    nxt = S_LANE;
      S_LANE:     nxt = a_lane;
      S_STRIPE:   nxt = a_stripe;
      S_PLL:      nxt = S_MODE;
      S_MODE:     nxt = S_CHAN;
      S_CHAN:     nxt = a_chan;
      S_BIAS:     nxt = a_bias;
      S_PLLON:    nxt = a_pllon;
      S_NORM:     nxt = a_norm;
      S_PHY:      nxt = a_phy;
      S_WAIT:     nxt = S_REL;
      S_REL: begin
        nxt      = unit_q ? S_ROUTE : S_IDLE;
        unit_nxt = 1'b0;
      end
      S_OFF_MAIN: nxt = S_OFF_CHAN;
      S_OFF_CHAN: nxt = S_OFF_PLL;
      S_OFF_PLL: begin
        if (!unit_q && dual && cfg_q.comp_present) begin
          nxt      = S_OFF_MAIN;
          unit_nxt = 1'b1;
        end else begin
          nxt = S_IDLE;
        end
      end
      default:    nxt = S_IDLE;
    endcase
  end

  always_comb begin
    wr_reg  = RG_MAIN;
    wr_data = '0;
    case (step_q)
      S_ROUTE:  begin wr_reg = RG_ROUTE;  wr_data = ROUTE_WORD; end
      S_LANE:   begin wr_reg = RG_LANE;   wr_data = LANE_WORD;  end
      S_STRIPE: begin wr_reg = RG_STRIPE; wr_data = {14'd0, swap, dual}; end
      S_PLL:    begin wr_reg = RG_PLL;    wr_data = pll_word;   end
      S_MODE:   wr_data = base;
      S_CHAN:   begin wr_reg = RG_CHAN;   wr_data = CHAN_WORD;  end
      S_BIAS:   begin
        wr_data = main_q;
        wr_data[MB_BIAS] = 1'b1;
        wr_data[MB_PHY]  = 1'b1;
      end
      S_PLLON:  begin wr_data = main_q; wr_data[MB_PLLON] = 1'b1; end
      S_NORM:   begin wr_data = main_q; wr_data[MB_NORM]  = 1'b1; end
      S_PHY:    begin wr_data = main_q; wr_data[MB_PHY]   = 1'b1; end
      S_REL:    begin
        wr_data = main_q;
        wr_data[MB_REL] = 1'b1;
        if (cfg_q.sep_phy) wr_data[MB_PHY] = 1'b1;
      end
      S_OFF_CHAN: wr_reg = RG_CHAN;
      S_OFF_PLL:  wr_reg = RG_PLL;
      default:    wr_reg = RG_MAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= S_IDLE;
      unit_q <= 1'b0;
      cfg_q  <= '0;
      freq_q <= '0;
      main_q <= '0;
    end else if (accept) begin
      cfg_q <= cfg_in;
      if (en_req) begin
        freq_q <= freq_in;
        unit_q <= dual_in && cfg_in.comp_present;
        step_q <= S_ROUTE;
      end else begin
        unit_q <= 1'b0;
        step_q <= S_OFF_MAIN;
      end
    end else if (step_q == S_WAIT) begin
      if (tmr_done) step_q <= S_REL;
    end else if (xfer) begin
      step_q <= nxt;
      unit_q <= unit_nxt;
      if (wr_reg == RG_MAIN) main_q <= wr_data;
    end
  end

  // R11: a presented beat is held until it transfers
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_reg) && $stable(wr_unit)));

  // R7: the pause only exists for the simple PLL and ends on the timer
  assert_wait_simple_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == S_WAIT) |-> !cfg_q.ext_pll);
  assert_wait_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((step_q == S_REL) && ($past(step_q) == S_WAIT)) |-> $past(tmr_done));

  // R6: the release word carries the separate PHY enable
  assert_rel_phy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_reg == RG_MAIN) && wr_data[MB_REL] && cfg_q.sep_phy) |-> wr_data[MB_PHY]);

  // R10: configuration is frozen while a sequence runs
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));
endmodule

// File: rtl/lvds_pwrseq.sv
module lvds_pwrseq
  import lvds_pwrseq_pkg::*;
#(
  parameter int FREQ_W     = 18,
  parameter int CLK_PER_US = 8,
  parameter int START_US   = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic [FREQ_W-1:0] freq_khz,
  input  logic              gen_new,
  input  logic              ext_pll,
  input  logic              has_pwd,
  input  logic              sep_phy,
  input  logic              dual_cap,
  input  logic              comp_present,
  input  logic [1:0]        link_mode,
  input  logic [2:0]        mode_code,
  input  logic              src_sel,
  output logic              busy,
  output logic [FREQ_W-1:0] freq_eff_khz,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic              wr_unit,
  output logic [2:0]        wr_reg,
  output logic [15:0]       wr_data
);
  seq_cfg_t          cfg_in, cfg_q;
  logic [FREQ_W-1:0] freq_q;
  logic [WORD_W-1:0] pll_word;
  logic              tmr_run, tmr_done;

  assign cfg_in = '{gen_new: gen_new, ext_pll: ext_pll, has_pwd: has_pwd,
                    sep_phy: sep_phy, dual_cap: dual_cap, comp_present: comp_present,
                    link_mode: link_mode, mode_code: mode_code, src_sel: src_sel};

  lvds_seq_fsm #(.FREQ_W(FREQ_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
    .cfg_in(cfg_in), .freq_in(freq_khz), .pll_word(pll_word), .tmr_done(tmr_done),
    .cfg_q(cfg_q), .freq_q(freq_q), .busy(busy), .tmr_run(tmr_run),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_unit(wr_unit),
    .wr_reg(wr_reg), .wr_data(wr_data)
  );

  lvds_freq_band #(.FREQ_W(FREQ_W)) u_band (
    .freq_in(freq_q), .gen_new(cfg_q.gen_new), .ext_pll(cfg_q.ext_pll),
    .freq_eff(freq_eff_khz), .pll_word(pll_word)
  );

  lvds_start_timer #(.CLK_PER_US(CLK_PER_US), .START_US(START_US)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .done(tmr_done)
  );

  // R1: the clamped frequency never leaves the supported range
  assert_clamp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_eff_khz >= FREQ_W'(F_MIN_EXT)) && (freq_eff_khz <= FREQ_W'(F_MAX)));

  // R10: beats appear only while a sequence is running
  assert_valid_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);
endmodule

// File: tb/test_lvds_pwrseq.sv
module test_lvds_pwrseq;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 18;
  localparam int CPU = 2;
  localparam int SUS = 100;
  localparam int LIMIT = CPU * SUS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_req = 0, dis_req = 0;
  logic [FW-1:0] freq_khz = '0;
  logic gen_new = 0, ext_pll = 0, has_pwd = 0, sep_phy = 0, dual_cap = 0, comp_present = 0;
  logic [1:0] link_mode = 0;
  logic [2:0] mode_code = 0;
  logic src_sel = 0;
  logic busy, wr_valid, wr_unit;
  logic wr_ready = 1'b1;
  logic [FW-1:0] freq_eff_khz;
  logic [2:0] wr_reg;
  logic [15:0] wr_data;

  int checks = 0, errors = 0, cyc = 0, last_hs = 0;
  bit bp_on = 0, finished = 0;

  typedef struct {
    bit u; int rg; int data; int gap; string req;
  } item_t;
  item_t expq[$];

  lvds_pwrseq #(.FREQ_W(FW), .CLK_PER_US(CPU), .START_US(SUS)) i_lvds_pwrseq (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .freq_khz(freq_khz),
    .gen_new(gen_new), .ext_pll(ext_pll), .has_pwd(has_pwd), .sep_phy(sep_phy),
    .dual_cap(dual_cap), .comp_present(comp_present), .link_mode(link_mode),
    .mode_code(mode_code), .src_sel(src_sel), .busy(busy), .freq_eff_khz(freq_eff_khz),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_unit(wr_unit), .wr_reg(wr_reg), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ready pattern: always high, or stalls every third cycle
  initial forever begin
    @(negedge clk);
    wr_ready = bp_on ? ((cyc % 3) != 1) : 1'b1;
  end

  // monitor: pop and compare on each transfer
  initial forever begin
    @(negedge clk);
    if (rst_n && wr_valid && wr_ready) begin
      int hs, gap;
      hs = cyc + 1;
      gap = hs - last_hs;
      last_hs = hs;
      if (expq.size() == 0) begin
        chk(0, "R10", "unexpected write reg", int'(wr_reg), -1);
      end else begin
        item_t it;
        it = expq.pop_front();
        chk(wr_unit == it.u && int'(wr_reg) == it.rg && int'(wr_data) == it.data,
            it.req, $sformatf("unit%0d/reg%0d data", it.u, it.rg), int'(wr_data),
            it.data + (it.rg << 16) + (int'(it.u) << 20) - ((int'(wr_reg) << 16) + (int'(wr_unit) << 20)) + (int'(wr_reg) << 16) + (int'(wr_unit) << 20) - (it.rg << 16) - (int'(it.u) << 20));
        if (it.gap != 0) chk(gap == it.gap, "R7", "cycles before release", gap, it.gap);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG", "run timed out", cyc, 0);
    summary();
  end

  function automatic int clampf(int f, bit ext);
    int lo = ext ? 5000 : 31000;
    if (f < lo) return lo;
    if (f > 148500) return 148500;
    return f;
  endfunction

  function automatic int exp_pll(int f, bit gn, bit ext);
    int fc, code, w;
    fc = clampf(f, ext);
    if (gn) code = (fc < 42000) ? 0 : (fc < 85000) ? 1 : (fc < 128000) ? 2 : 3;
    else    code = (fc < 39000) ? 0 : (fc < 61000) ? 1 : (fc < 121000) ? 2 : 3;
    w = code;
    if (!gn && code != 3) w = w | 'h30;
    if (ext) w = w | 'h100;
    return w;
  endfunction

  task automatic push(bit u, int rg, int data, int gap, string req);
    item_t it;
    it.u = u; it.rg = rg; it.data = data; it.gap = gap; it.req = req;
    expq.push_back(it);
  endtask

  task automatic exp_unit(bit u, bit skip, bit sw, bit dl, int f);
    int m, rel;
    push(u, 0, 'h39, 0, "R4");
    push(u, 1, 'hE4, 0, "R4");
    if (dual_cap) push(u, 2, (sw ? 2 : 0) | (dl ? 1 : 0), 0, "R8");
    if (!skip) push(u, 3, exp_pll(f, gen_new, ext_pll), 0, gen_new ? "R3" : "R2");
    m = int'(mode_code) | (src_sel ? 8 : 0);
    push(u, 4, m, 0, "R4");
    push(u, 5, 'h1F, 0, "R4");
    if (!gen_new) begin m = m | 'h30; push(u, 4, m, 0, "R5"); end
    if (!ext_pll) begin m = m | 'h40; push(u, 4, m, 0, "R5"); end
    if (has_pwd)  begin m = m | 'h80; push(u, 4, m, 0, "R5"); end
    if (sep_phy && !has_pwd) begin m = m | 'h20; push(u, 4, m, 0, "R5"); end
    rel = m | 'h100 | (sep_phy ? 'h20 : 0);
    push(u, 4, rel, bp_on ? 0 : (ext_pll ? 1 : LIMIT + 1), "R6");
  endtask

  task automatic exp_enable(int f);
    bit dl = dual_cap && (link_mode != 0);
    if (dl && comp_present) exp_unit(1, 1, 0, 1, f);
    exp_unit(0, dl && !comp_present, dl && comp_present && link_mode == 2, dl, f);
  endtask

  task automatic exp_disable();
    bit dl = dual_cap && (link_mode != 0);
    push(0, 4, 0, 0, "R9"); push(0, 5, 0, 0, "R9"); push(0, 3, 0, 0, "R9");
    if (dl && comp_present) begin
      push(1, 4, 0, 0, "R9"); push(1, 5, 0, 0, "R9"); push(1, 3, 0, 0, "R9");
    end
  endtask

  task automatic set_cfg(bit gn, bit ex, bit pw, bit sp, bit dc, bit cp, int lm, int mc, bit ss);
    gen_new = gn; ext_pll = ex; has_pwd = pw; sep_phy = sp; dual_cap = dc;
    comp_present = cp; link_mode = 2'(lm); mode_code = 3'(mc); src_sel = ss;
  endtask

  task automatic wait_idle(string req);
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, req, "writes still expected", expq.size(), 0);
  endtask

  task automatic start_enable(int f, bit both);
    exp_enable(f);
    freq_khz = FW'(f);
    en_req = 1; dis_req = both;
    @(negedge clk);
    en_req = 0; dis_req = 0;
    chk(busy == 1'b1, "R10", "busy after request", busy, 1);
    chk(int'(freq_eff_khz) == clampf(f, ext_pll), "R1", "clamped frequency", int'(freq_eff_khz), clampf(f, ext_pll));
  endtask

  task automatic run_enable(int f, string req);
    start_enable(f, 0);
    wait_idle(req);
  endtask

  task automatic run_disable();
    exp_disable();
    dis_req = 1;
    @(negedge clk);
    dis_req = 0;
    wait_idle("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R10", "busy in reset", busy, 0);
    chk(wr_valid == 0, "R11", "valid in reset", wr_valid, 0);
    rst_n = 1;
    @(negedge clk);

    // older generation, simple PLL, band 1 with enable bits, pause before release
    set_cfg(0, 0, 0, 0, 0, 0, 0, 3, 1);
    run_enable(50000, "R2");
    run_disable();

    // band edges, older generation, and clamp of a low request
    run_enable(38999, "R2");
    run_enable(39000, "R2");
    run_enable(121000, "R2");
    run_enable(20000, "R1");

    // newer generation with normal-mode bit
    set_cfg(1, 0, 1, 0, 0, 0, 0, 4, 0);
    run_enable(100000, "R3");
    run_enable(127999, "R3");
    run_enable(128000, "R3");

    // extended PLL, normal mode plus separate PHY committed with release, no pause
    set_cfg(1, 1, 1, 1, 1, 0, 0, 1, 0);
    run_enable(3000, "R6");

    // dual link, odd-first, companion first, clamp high
    set_cfg(1, 1, 0, 1, 1, 1, 2, 0, 1);
    run_enable(200000, "R8");
    run_disable();

    // dual link without companion: PLL skipped, only one unit
    set_cfg(1, 0, 1, 0, 1, 0, 1, 2, 0);
    run_enable(60000, "R8");
    run_disable();

    // requests while busy are ignored
    set_cfg(0, 0, 0, 0, 0, 0, 0, 5, 0);
    start_enable(70000, 0);
    repeat (20) @(negedge clk);
    chk(busy == 1, "R10", "busy during pause", busy, 1);
    freq_khz = FW'(140000);
    en_req = 1; dis_req = 1;
    @(negedge clk);
    en_req = 0; dis_req = 0;
    @(negedge clk);
    chk(int'(freq_eff_khz) == 70000, "R10", "frequency kept while busy", int'(freq_eff_khz), 70000);
    wait_idle("R10");

    // simultaneous enable and disable: enable wins
    set_cfg(1, 1, 0, 0, 0, 0, 0, 6, 1);
    start_enable(90000, 1);
    wait_idle("R10");

    // back-pressure on a dual-link sequence
    bp_on = 1;
    set_cfg(0, 0, 1, 1, 1, 1, 1, 7, 1);
    run_enable(45000, "R11");
    run_disable();
    bp_on = 0;

    summary();
  end
endmodule